// File: doc/BRIEF.md
# Binary-Weighted Time-Slot Pixel Sequencer

This block controls a display pixel that holds a 4-bit gray level and shows it by time modulation. It does not compare the level against a ramp. Each fixed period is cut into four back-to-back slots whose lengths stand in the ratio 8:4:2:1, with the longest slot first. The electrode is driven high or low for a whole slot, according to one bit of the gray value. The sequencer produces the four slot strobes, the common-electrode level and the pixel bit. A parameter sets how many clock cycles make one unit slot.

The block has three operating modes.
- **Pass-through:** the store is cut off and the pixel copies the serial data input.
- **Capture:** the strobes run in slot order, and each strobe writes the incoming data bit into its own store cell.
- **Hold:** no data is needed. The strobes keep cycling and the stored bits are replayed slot by slot.

In hold mode, a frame tick asks for a polarity reversal at the next period boundary. In a reversed frame the pixel shows the complement of each stored bit and the common level is high. Mode requests are sampled only at period boundaries, so a period is never cut short.

Top module: `tslot_pixel_seq`

## Requirements
- R1: After reset the block is in pass-through mode with polarity non-inverting. All strobes and the common level are low, and the store holds 0000.
- R2: The slot sequence repeats every 15 units of UNIT_CYC cycles, with no gap between slots.
  - Slot 0 lasts 8 units and raises strobe bit 0.
  - Slot 1 lasts 4 units and raises strobe bit 1.
  - Slot 2 lasts 2 units and raises strobe bit 2.
  - Slot 3 lasts 1 unit and raises strobe bit 3.
  - Strobes are high in capture and hold modes only. In pass-through mode they are all low.
- R3: At most one strobe is high at any time, and at most one strobe rises on any clock edge.
- R4: The mode request is encoded 00 pass-through, 01 capture, 10 hold; 11 is treated as pass-through. The request is taken only at the clock edge that ends a period. A request changed in the middle of a period has no effect until then.
- R5: In pass-through and capture modes the pixel output equals the data input.
- R6: In capture mode, the data bit present at the last cycle of slot k is written into gray bit 3−k. Slot 0 therefore captures the MSB.
- R7: In hold mode, during slot k the pixel output is gray bit 3−k, exclusive-ORed with the polarity.
- R8: The polarity is set by the frame tick, and the common level follows it.
  - A frame tick seen in hold mode sets a pending reversal.
  - At a period boundary where the block stays in hold, a pending reversal toggles the polarity, and the pending flag is cleared.
  - Entering or leaving hold, or being outside it, forces polarity non-inverting.
  - The common level equals the polarity.
- R9: The store changes only through capture-mode writes. Its value survives pass-through and hold periods and is replayed again on the next return to hold.
- R10: A stored 1010, replayed with one frame tick per period, appears in slot order as 1010 and 0101 on alternate periods, with no data supplied.
- R11: In every full hold period, the output high time in units equals the stored value in a non-inverting period and 15 minus the value in an inverting one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_req | input | 2 | Requested mode: 00 pass-through, 01 capture, 10 hold, 11 pass-through |
| data_in | input | 1 | Serial pixel data bit |
| frame_tick | input | 1 | Frame pulse requesting a polarity reversal in hold mode |
| slot_strb | output | 4 | One-hot slot strobes, bit k for slot k |
| vcom_hi | output | 1 | Common-electrode level, high in inverting frames |
| pix_out | output | 1 | Pixel electrode bit |

## Verification
A wrong slot counter shows on the strobes within one cycle. A store cell that is written at the wrong time or captures the wrong bit only shows once hold mode replays it, at the start of the affected slot. A lost or extra polarity toggle flips the common level at the very next boundary, and it also turns the high time of that period from v into 15−v units. The bench therefore compares strobes, common level and pixel bit every cycle, and checks the slot pattern and the unit-count high time of every full hold period.

// File: rtl/tslot_pkg.sv
package tslot_pkg;

  typedef enum logic [1:0] {
    MODE_NORM  = 2'b00,
    MODE_PRE   = 2'b01,
    MODE_STILL = 2'b10
  } mode_e;

  // Request code 11 is folded onto pass-through.
  function automatic mode_e decode_req(input logic [1:0] req);
    case (req)
      2'b01:   return MODE_PRE;
      2'b10:   return MODE_STILL;
      default: return MODE_NORM;
    endcase
  endfunction

endpackage

// File: rtl/tslot_timer.sv
module tslot_timer #(
  parameter  int UNIT_CYC  = 4,
  parameter  int GRAY_W    = 4,
  localparam int PER_UNITS = (1 << GRAY_W) - 1,
  localparam int UW        = $clog2(PER_UNITS + 1),
  localparam int CW        = (UNIT_CYC > 1) ? $clog2(UNIT_CYC) : 1,
  localparam int SW        = (GRAY_W > 1) ? $clog2(GRAY_W) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [SW-1:0] slot_idx,
  output logic          bnd
);

  logic [CW-1:0] ucnt_q, ucnt_n;
  logic [UW-1:0] uidx_q, uidx_n;
  logic          ucnt_last, uidx_last;

  assign ucnt_last = (ucnt_q == CW'(UNIT_CYC - 1));
  assign uidx_last = (uidx_q == UW'(PER_UNITS - 1));
  assign bnd       = ucnt_last & uidx_last;

  always_comb begin
    ucnt_n = ucnt_last ? '0 : ucnt_q + CW'(1);
    uidx_n = uidx_last ? '0 : uidx_q + UW'(1);
  end

  // Slot k starts at unit 2^W - 2^(W-k); the last start passed wins.
  always_comb begin
    slot_idx = '0;
    for (int k = 0; k < GRAY_W; k++) begin
      if (32'(uidx_q) >= ((1 << GRAY_W) - (1 << (GRAY_W - k))))
        slot_idx = SW'(k);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ucnt_q <= '0;
    else        ucnt_q <= ucnt_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         uidx_q <= '0;
    else if (ucnt_last) uidx_q <= uidx_n;
  end

  assert_unit_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    uidx_q <= UW'(PER_UNITS - 1));

  assert_wrap_slot0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bnd |=> (slot_idx == '0));

endmodule

// File: rtl/tslot_mode_ctl.sv
module tslot_mode_ctl
  import tslot_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_req,
  input  logic       frame_tick,
  input  logic       bnd,
  output mode_e      mode_q,
  output logic       pol_q
);

  mode_e mode_n, req_mode;
  logic  pol_n, pend_q, pend_n;

  assign req_mode = decode_req(mode_req);

  always_comb begin
    mode_n = mode_q;
    pol_n  = pol_q;
    pend_n = pend_q | frame_tick;
    if (bnd) begin
      mode_n = req_mode;
      pend_n = 1'b0;
      if (mode_q == MODE_STILL && req_mode == MODE_STILL)
        pol_n = pol_q ^ (pend_q | frame_tick);
      else
        pol_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_NORM;
      pol_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      mode_q <= mode_n;
      pol_q  <= pol_n;
      pend_q <= pend_n;
    end
  end

  assert_mode_at_bnd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !bnd |=> $stable(mode_q));

  assert_pol_at_bnd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !bnd |=> $stable(pol_q));

  assert_pol_only_still_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != MODE_STILL) |-> !pol_q);

endmodule

// File: rtl/tslot_store.sv
module tslot_store #(
  parameter  int GRAY_W = 4,
  localparam int SW     = (GRAY_W > 1) ? $clog2(GRAY_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SW-1:0]     slot_idx,
  input  logic              data_in,
  output logic [GRAY_W-1:0] store_q,
  output logic              cur_bit
);

  for (genvar b = 0; b < GRAY_W; b++) begin : g_cell
    logic cell_we;
    assign cell_we = wr_en && (slot_idx == SW'(GRAY_W - 1 - b));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       store_q[b] <= 1'b0;
      else if (cell_we) store_q[b] <= data_in;
    end
  end

  always_comb begin
    cur_bit = 1'b0;
    for (int k = 0; k < GRAY_W; k++) begin
      if (slot_idx == SW'(k)) cur_bit = store_q[GRAY_W - 1 - k];
    end
  end

  assert_store_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(store_q));

endmodule

// File: rtl/tslot_pixel_seq.sv
module tslot_pixel_seq
  import tslot_pkg::*;
#(
  parameter  int UNIT_CYC = 4,
  localparam int GRAY_W   = 4,
  localparam int SW       = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_req,
  input  logic       data_in,
  input  logic       frame_tick,
  output logic [3:0] slot_strb,
  output logic       vcom_hi,
  output logic       pix_out
);

  logic              rst_ff1, rst_i;
  logic [SW-1:0]     slot_idx;
  logic              bnd, pol_q, cur_bit;
  logic [GRAY_W-1:0] store_q;
  mode_e             mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_ff1 <= 1'b0;
      rst_i   <= 1'b0;
    end else begin
      rst_ff1 <= 1'b1;
      rst_i   <= rst_ff1;
    end
  end

  tslot_timer #(.UNIT_CYC(UNIT_CYC), .GRAY_W(GRAY_W)) u_timer (
    .clk(clk), .rst_n(rst_i), .slot_idx(slot_idx), .bnd(bnd)
  );

  tslot_mode_ctl u_mode (
    .clk(clk), .rst_n(rst_i), .mode_req(mode_req), .frame_tick(frame_tick),
    .bnd(bnd), .mode_q(mode_q), .pol_q(pol_q)
  );

  tslot_store #(.GRAY_W(GRAY_W)) u_store (
    .clk(clk), .rst_n(rst_i), .wr_en(mode_q == MODE_PRE), .slot_idx(slot_idx),
    .data_in(data_in), .store_q(store_q), .cur_bit(cur_bit)
  );

  for (genvar k = 0; k < GRAY_W; k++) begin : g_strb
    assign slot_strb[k] = (mode_q != MODE_NORM) && (slot_idx == SW'(k));
  end

  assign vcom_hi = pol_q;
  assign pix_out = (mode_q == MODE_STILL) ? (cur_bit ^ pol_q) : data_in;

  assert_strb_onehot_R3: assert property (@(posedge clk) disable iff (!rst_i)
    $onehot0(slot_strb));

  assert_strb_one_rise_R3: assert property (@(posedge clk) disable iff (!rst_i)
    $countones(slot_strb & ~$past(slot_strb)) <= 1);

  assert_strb_quiet_norm_R2: assert property (@(posedge clk) disable iff (!rst_i)
    (mode_q == MODE_NORM) |-> (slot_strb == '0));

  assert_pass_through_R5: assert property (@(posedge clk) disable iff (!rst_i)
    (mode_q != MODE_STILL) |-> (pix_out == data_in));

endmodule

// File: tb/tslot_pixel_seq_test.sv
module tslot_pixel_seq_test;
  localparam int U   = 3;
  localparam int PER = 15 * U;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode_req = 2'b00;
  logic       data_in = 1'b0, frame_tick = 1'b0;
  logic [3:0] slot_strb;
  logic       vcom_hi, pix_out;

  int nchk = 0, nbad = 0;
  int m_ph = 0, m_mode = 0, m_pol = 0, m_pend = 0, m_rs = 0;
  logic [3:0] m_st = 4'b0;
  logic [3:0] load_v = 4'b0;
  bit feed = 1'b0;
  int hi = 0; bit full = 1'b0; logic [3:0] pat = 4'b0, pat_last = 4'b0;

  always #4 clk = ~clk;

  tslot_pixel_seq #(.UNIT_CYC(U)) uut (
    .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .data_in(data_in),
    .frame_tick(frame_tick), .slot_strb(slot_strb), .vcom_hi(vcom_hi), .pix_out(pix_out)
  );

  function automatic int slot_of(int ph);
    int u = ph / U;
    if (u < 8) return 0;
    if (u < 12) return 1;
    if (u < 14) return 2;
    return 3;
  endfunction

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model, advanced on every rising edge.
  always @(posedge clk) begin
    int nm;
    if (!rst_n || m_rs < 2) begin
      m_rs = rst_n ? m_rs + 1 : 0;
      m_ph = 0; m_mode = 0; m_pol = 0; m_pend = 0; m_st = 4'b0;
    end else begin
      if (m_mode == 1) m_st[3 - slot_of(m_ph)] = data_in;
      if (m_ph == PER - 1) begin
        nm = (mode_req == 2'b01) ? 1 : (mode_req == 2'b10) ? 2 : 0;
        if (m_mode == 2 && nm == 2) m_pol = m_pol ^ (m_pend | frame_tick);
        else m_pol = 0;
        m_mode = nm; m_pend = 0; m_ph = 0;
      end else begin
        m_pend = m_pend | frame_tick;
        m_ph++;
      end
    end
  end

  // Compare on the falling edge, away from the active edge.
  always @(negedge clk) begin
    int s;
    logic [3:0] exp_v;
    s = slot_of(m_ph);
    chk("R2 strobes", slot_strb, (m_mode != 0) ? (1 << s) : 0);
    chk("R3 onehot", ($countones(slot_strb) <= 1) ? 1 : 0, 1);
    chk("R8 common level", vcom_hi, m_pol);
    if (m_mode == 2) chk("R7 hold replay", pix_out, m_st[3 - s] ^ m_pol[0]);
    else             chk("R5 pass-through", pix_out, data_in);
    if (m_ph == 0) begin full = (m_mode == 2); hi = 0; pat = 4'b0; end
    if (m_mode != 2) full = 1'b0;
    if (pix_out) hi++;
    if (m_ph == 0 || m_ph == 8 * U || m_ph == 12 * U || m_ph == 14 * U)
      pat = {pat[2:0], pix_out};
    if (m_ph == PER - 1 && full && rst_n) begin
      exp_v = m_pol[0] ? ~m_st : m_st;
      chk("R11 high time", hi, U * int'(exp_v));
      chk((m_st == 4'b1010) ? "R10 alternating pattern" : "R6 captured pattern", pat, exp_v);
      pat_last = pat;
    end
  end

  task automatic step();
    @(posedge clk); #2;
    if (feed) data_in = load_v[3 - slot_of(m_ph)];
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic tick();
    frame_tick = 1'b1; step(); frame_tick = 1'b0;
  endtask

  task automatic load(logic [3:0] v);
    load_v = v; feed = 1'b1; mode_req = 2'b01;
    while (!(m_mode == 1 && m_ph == 0)) step();
    mode_req = 2'b10;
    while (m_mode != 2) step();
    feed = 1'b0;
  endtask

  // One hold period per call; the tick lands mid-period.
  task automatic frame(bit with_tick);
    run(10);
    if (with_tick) tick();
    while (m_ph != 0) step();
  endtask

  initial begin
    #160000;
    nbad++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 strobes in reset", slot_strb, 0);
    chk("R1 common in reset", vcom_hi, 0);
    @(posedge clk); #2; rst_n = 1'b1;
    run(3);
    chk("R1 mode after reset", m_mode, 0);
    // Pass-through with toggling data and stray ticks.
    for (int i = 0; i < 40; i++) begin
      data_in = i[0] ^ i[2];
      frame_tick = (i % 9 == 0);
      step();
    end
    frame_tick = 1'b0;
    // Hold straight after reset: the store is zero.
    mode_req = 2'b10;
    while (m_mode != 2) step();
    frame(1'b1);
    chk("R1 store zero", pat_last, 0);
    frame(1'b1);
    chk("R8 inverted zero", pat_last, 15);
    // 1010 capture and replay with ticks.
    load(4'b1010);
    frame(1'b1);
    chk("R10 first frame", pat_last, 4'b1010);
    frame(1'b1);
    chk("R10 second frame", pat_last, 4'b0101);
    frame(1'b1);
    frame(1'b1);
    // Mid-period request is deferred to the boundary.
    run(5);
    mode_req = 2'b00;
    step();
    @(negedge clk);
    chk("R4 deferred request", (slot_strb != 0) ? 1 : 0, 1);
    while (m_mode != 0) step();
    for (int i = 0; i < 30; i++) begin data_in = i[1]; step(); end
    mode_req = 2'b10;
    while (m_mode != 2) step();
    frame(1'b0);
    chk("R9 store kept", pat_last, 4'b1010);
    // No ticks: polarity stays non-inverting.
    load(4'b0110);
    frame(1'b0);
    frame(1'b0);
    chk("R8 no tick no flip", vcom_hi, 0);
    chk("R6 capture 0110", pat_last, 4'b0110);
    load(4'b1111);
    frame(1'b1);
    frame(1'b1);
    load(4'b0001);
    frame(1'b1);
    frame(1'b1);
    // A capture request withdrawn before the boundary changes nothing.
    run(7);
    mode_req = 2'b01; run(5); mode_req = 2'b10;
    frame(1'b0);
    chk("R4 withdrawn request", m_mode, 2);
    chk("R9 store after withdrawn", m_st, 4'b0001);
    // Code 11 is pass-through.
    mode_req = 2'b11;
    while (m_mode != 0) step();
    run(4);
    chk("R4 code 11 strobes", slot_strb, 0);
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule